// File: doc/BRIEF.md
# Packed-Priority Interrupt Resolver

This block selects one interrupt source out of a request vector. Each source has a 4-bit priority. All the priorities arrive as one flat packed bus. The block reports the index and priority of the winning source, a flag that says whether any source is requesting, and a flag that says whether the winner is above a 5-bit threshold. The surrounding controller uses that last flag to decide whether to raise its normal interrupt line.

Selection runs through a balanced binary tree of two-input merge cells. Each cell keeps the entry from the higher-numbered half when the priorities are equal. The tree therefore gives the same result as a scan from the top source down that replaces its candidate only on a strictly greater priority. A single output register captures the result, so the block has a latency of one clock.

Top module: `prio_resolver`

## Requirements
- R1: The priority of source i is taken from bits [4i+3:4i] of `prio_i`. This is nibble (i mod 8) of 32-bit word (i/8).
- R2: When at least one request bit is set, `win_valid_o` is 1. `win_idx_o` then names a requesting source with the largest priority among all requesting sources, and `win_prio_o` equals that source's priority.
- R3: When several requesting sources share the largest priority, the highest-numbered of them is reported.
- R4: A requesting source with priority 0 is a valid winner. If it is the only request, the outputs are valid=1, that index, and priority 0.
- R5: With no request bit set, the outputs are `win_valid_o`=0, `win_idx_o`=6'h3F, `win_prio_o`=4'hF and `win_above_o`=0, whatever the threshold.
- R6: For a threshold below 5'h1F, `win_above_o` is 1 exactly when a winner exists and its priority, zero-extended, is strictly greater than `thr_i`.
- R7: For a threshold of 5'h1F, `win_above_o` equals `win_valid_o`.
- R8: All outputs are registered. Inputs applied before a rising edge show up at the outputs after that edge, and do not show up before it.
- R9: While `rst_n` is low, the outputs hold the empty values of R5.
- R10: The priority of a source whose request bit is 0 has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 64 | Request vector, one bit per source |
| prio_i | input | 256 | Packed priorities, 4 bits per source |
| thr_i | input | 5 | Threshold for the above flag |
| win_valid_o | output | 1 | At least one request was present |
| win_idx_o | output | 6 | Index of the winning source |
| win_prio_o | output | 4 | Priority of the winning source |
| win_above_o | output | 1 | Winner beats the threshold |

## Verification
Every result is due one rising edge after its inputs are applied. The bench drives inputs at a falling edge and compares all four outputs at the next falling edge, when exactly one capturing edge has passed. One directed step also samples just after the drive, before the edge, to show that the new inputs are not yet visible. The checker keeps a registered copy of the inputs, so each assertion compares the outputs with the inputs of the previous edge.

// File: rtl/prio_res_pkg.sv
package prio_res_pkg;

  localparam int unsigned DEF_SRC    = 64;
  localparam int unsigned DEF_PRIO_W = 4;
  localparam int unsigned DEF_THR_W  = 5;

  // Threshold rule: strictly above, or saturated threshold lets any winner through.
  function automatic logic thr_pass(input int unsigned prio,
                                    input int unsigned thr,
                                    input int unsigned thr_max,
                                    input logic        any_req);
    return any_req && ((prio > thr) || (thr == thr_max));
  endfunction

endpackage

// File: rtl/prio_merge.sv
module prio_merge #(
  parameter int unsigned PRIO_W = 4,
  parameter int unsigned IDX_W  = 6
) (
  input  logic              lo_vld,
  input  logic [PRIO_W-1:0] lo_prio,
  input  logic [IDX_W-1:0]  lo_idx,
  input  logic              hi_vld,
  input  logic [PRIO_W-1:0] hi_prio,
  input  logic [IDX_W-1:0]  hi_idx,
  output logic              out_vld,
  output logic [PRIO_W-1:0] out_prio,
  output logic [IDX_W-1:0]  out_idx
);

  // Upper half holds the larger indices, so it keeps ties.
  logic take_hi;
  assign take_hi  = hi_vld && (!lo_vld || (hi_prio >= lo_prio));
  assign out_vld  = lo_vld | hi_vld;
  assign out_prio = take_hi ? hi_prio : lo_prio;
  assign out_idx  = take_hi ? hi_idx  : lo_idx;

endmodule

// File: rtl/prio_tree.sv
module prio_tree #(
  parameter int unsigned NUM_SRC = 64,
  parameter int unsigned PRIO_W  = 4,
  localparam int unsigned IDX_W  = $clog2(NUM_SRC),
  localparam int unsigned NODES  = 2 * NUM_SRC - 1
) (
  input  logic [NUM_SRC-1:0]        req,
  input  logic [NUM_SRC*PRIO_W-1:0] prio_flat,
  output logic                      root_vld,
  output logic [PRIO_W-1:0]         root_prio,
  output logic [IDX_W-1:0]          root_idx
);

  // Heap layout: node k has children 2k+1 (lower indices) and 2k+2.
  // Leaf of source i sits at NUM_SRC-1+i; NUM_SRC must be a power of two.
  logic              nd_vld  [NODES];
  logic [PRIO_W-1:0] nd_prio [NODES];
  logic [IDX_W-1:0]  nd_idx  [NODES];

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_leaf
    assign nd_vld [NUM_SRC-1+i] = req[i];
    assign nd_prio[NUM_SRC-1+i] = prio_flat[PRIO_W*i +: PRIO_W];
    assign nd_idx [NUM_SRC-1+i] = IDX_W'(i);
  end

  for (genvar k = 0; k < NUM_SRC-1; k++) begin : g_node
    prio_merge #(.PRIO_W(PRIO_W), .IDX_W(IDX_W)) u_merge (
      .lo_vld  (nd_vld [2*k+1]),
      .lo_prio (nd_prio[2*k+1]),
      .lo_idx  (nd_idx [2*k+1]),
      .hi_vld  (nd_vld [2*k+2]),
      .hi_prio (nd_prio[2*k+2]),
      .hi_idx  (nd_idx [2*k+2]),
      .out_vld (nd_vld [k]),
      .out_prio(nd_prio[k]),
      .out_idx (nd_idx [k])
    );
  end

  assign root_vld  = nd_vld[0];
  assign root_prio = nd_prio[0];
  assign root_idx  = nd_idx[0];

endmodule

// File: rtl/prio_out_stage.sv
module prio_out_stage
  import prio_res_pkg::*;
#(
  parameter int unsigned PRIO_W = 4,
  parameter int unsigned IDX_W  = 6,
  parameter int unsigned THR_W  = 5,
  localparam int unsigned THR_MAX = (1 << THR_W) - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              root_vld,
  input  logic [PRIO_W-1:0] root_prio,
  input  logic [IDX_W-1:0]  root_idx,
  input  logic [THR_W-1:0]  thr,
  output logic              win_valid,
  output logic [IDX_W-1:0]  win_idx,
  output logic [PRIO_W-1:0] win_prio,
  output logic              win_above
);

  logic above_nxt;
  assign above_nxt = thr_pass(32'(root_prio), 32'(thr), THR_MAX, root_vld);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_valid <= 1'b0;
      win_idx   <= '1;
      win_prio  <= '1;
      win_above <= 1'b0;
    end else begin
      win_valid <= root_vld;
      win_idx   <= root_vld ? root_idx  : '1;
      win_prio  <= root_vld ? root_prio : '1;
      win_above <= above_nxt;
    end
  end

endmodule

// File: rtl/prio_resolver.sv
module prio_resolver
  import prio_res_pkg::*;
#(
  parameter int unsigned NUM_SRC = DEF_SRC,
  parameter int unsigned PRIO_W  = DEF_PRIO_W,
  parameter int unsigned THR_W   = DEF_THR_W,
  localparam int unsigned IDX_W  = $clog2(NUM_SRC)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NUM_SRC-1:0]        req_i,
  input  logic [NUM_SRC*PRIO_W-1:0] prio_i,
  input  logic [THR_W-1:0]          thr_i,
  output logic                      win_valid_o,
  output logic [IDX_W-1:0]          win_idx_o,
  output logic [PRIO_W-1:0]         win_prio_o,
  output logic                      win_above_o
);

  logic              root_vld;
  logic [PRIO_W-1:0] root_prio;
  logic [IDX_W-1:0]  root_idx;

  prio_tree #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W)) u_tree (
    .req      (req_i),
    .prio_flat(prio_i),
    .root_vld (root_vld),
    .root_prio(root_prio),
    .root_idx (root_idx)
  );

  prio_out_stage #(.PRIO_W(PRIO_W), .IDX_W(IDX_W), .THR_W(THR_W)) u_out (
    .clk      (clk),
    .rst_n    (rst_n),
    .root_vld (root_vld),
    .root_prio(root_prio),
    .root_idx (root_idx),
    .thr      (thr_i),
    .win_valid(win_valid_o),
    .win_idx  (win_idx_o),
    .win_prio (win_prio_o),
    .win_above(win_above_o)
  );

endmodule

// File: rtl/prio_resolver_chk.sv
module prio_resolver_chk #(
  parameter int unsigned NUM_SRC = 64,
  parameter int unsigned PRIO_W  = 4,
  parameter int unsigned THR_W   = 5,
  localparam int unsigned IDX_W  = $clog2(NUM_SRC),
  localparam logic [THR_W-1:0] THR_MAX = '1
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic [NUM_SRC-1:0]        req_i,
  input logic [NUM_SRC*PRIO_W-1:0] prio_i,
  input logic [THR_W-1:0]          thr_i,
  input logic                      win_valid_o,
  input logic [IDX_W-1:0]          win_idx_o,
  input logic [PRIO_W-1:0]         win_prio_o,
  input logic                      win_above_o,
  input logic                      root_vld
);

  logic [NUM_SRC-1:0]        req_q;
  logic [NUM_SRC*PRIO_W-1:0] prio_q;
  logic [THR_W-1:0]          thr_q;
  logic                      better_exists;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q  <= '0;
      prio_q <= '0;
      thr_q  <= '0;
    end else begin
      req_q  <= req_i;
      prio_q <= prio_i;
      thr_q  <= thr_i;
    end
  end

  always_comb begin
    better_exists = 1'b0;
    for (int j = 0; j < NUM_SRC; j++) begin
      if (req_q[j] && ((prio_q[j*PRIO_W +: PRIO_W] > win_prio_o) ||
          ((prio_q[j*PRIO_W +: PRIO_W] == win_prio_o) && (j > int'(win_idx_o)))))
        better_exists = 1'b1;
    end
  end

  assert_root_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
    root_vld == (|req_i));

  assert_winner_requested_R2: assert property (@(posedge clk) disable iff (!rst_n)
    win_valid_o |-> (req_q[win_idx_o] &&
                     (win_prio_o == prio_q[int'(win_idx_o)*PRIO_W +: PRIO_W])));

  assert_no_better_source_R3: assert property (@(posedge clk) disable iff (!rst_n)
    win_valid_o |-> !better_exists);

  assert_empty_all_ones_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !win_valid_o |-> ((win_idx_o == '1) && (win_prio_o == '1) && !win_above_o));

  assert_thr_strict_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (win_above_o && (thr_q != THR_MAX)) |-> (32'(win_prio_o) > 32'(thr_q)));

  assert_thr_saturated_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (thr_q == THR_MAX) |-> (win_above_o == win_valid_o));

  assert_one_cycle_latency_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> (win_valid_o == $past(|req_i)));

endmodule

bind prio_resolver prio_resolver_chk #(
  .NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W), .THR_W(THR_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_i      (req_i),
  .prio_i     (prio_i),
  .thr_i      (thr_i),
  .win_valid_o(win_valid_o),
  .win_idx_o  (win_idx_o),
  .win_prio_o (win_prio_o),
  .win_above_o(win_above_o),
  .root_vld   (root_vld)
);

// File: tb/prio_resolver_tb.sv
module prio_resolver_tb;

  localparam int CLK_PERIOD = 10;
  localparam int N  = 64;
  localparam int PW = 4;
  localparam int TW = 5;
  localparam int IW = 6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  req = '0;
  logic [N*PW-1:0] prio = '0;
  logic [TW-1:0] thr = '0;
  logic          win_valid;
  logic [IW-1:0] win_idx;
  logic [PW-1:0] win_prio;
  logic          win_above;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  prio_resolver u_dut (
    .clk(clk), .rst_n(rst_n), .req_i(req), .prio_i(prio), .thr_i(thr),
    .win_valid_o(win_valid), .win_idx_o(win_idx),
    .win_prio_o(win_prio), .win_above_o(win_above)
  );

  // Reference: scan downward from the top source, replace only on strictly greater.
  function automatic void ref_pick(input logic [N-1:0] r, input logic [N*PW-1:0] p,
                                   input logic [TW-1:0] t, output logic v,
                                   output logic [IW-1:0] ix, output logic [PW-1:0] pr,
                                   output logic ab);
    int best = -1;
    int bidx = -1;
    for (int s = N-1; s >= 0; s--) begin
      int word = s / 8;
      int nib  = s % 8;
      int sp   = int'(p[32*word + 4*nib +: 4]);
      if (r[s] && sp > best) begin best = sp; bidx = s; end
    end
    v  = (bidx >= 0);
    ix = v ? IW'(bidx) : '1;
    pr = v ? PW'(best) : '1;
    ab = v && ((best > int'(t)) || (t == 5'h1F));
  endfunction

  task automatic check4(input string tag, input logic v, input logic [IW-1:0] ix,
                        input logic [PW-1:0] pr, input logic ab);
    checks++;
    if (win_valid !== v || win_idx !== ix || win_prio !== pr || win_above !== ab) begin
      errors++;
      $display("FAIL %s: got v=%0b idx=%0d prio=%0d above=%0b, expected v=%0b idx=%0d prio=%0d above=%0b",
               tag, win_valid, win_idx, win_prio, win_above, v, ix, pr, ab);
    end
  endtask

  // Drive at a falling edge, compare one capturing edge later.
  task automatic apply(input string tag, input logic [N-1:0] r,
                       input logic [N*PW-1:0] p, input logic [TW-1:0] t);
    logic v; logic [IW-1:0] ix; logic [PW-1:0] pr; logic ab;
    @(negedge clk);
    req = r; prio = p; thr = t;
    ref_pick(r, p, t, v, ix, pr, ab);
    @(negedge clk);
    check4(tag, v, ix, pr, ab);
  endtask

  function automatic logic [N*PW-1:0] set_nib(input logic [N*PW-1:0] p, input int s,
                                               input logic [PW-1:0] val);
    logic [N*PW-1:0] q = p;
    q[4*s +: 4] = val;
    return q;
  endfunction

  function automatic logic [N*PW-1:0] rand_prio(input bit narrow);
    logic [N*PW-1:0] q;
    for (int w = 0; w < N*PW/32; w++) q[32*w +: 32] = $urandom;
    if (narrow) for (int s = 0; s < N; s++) q[4*s +: 4] = q[4*s +: 4] & 4'h3;
    return q;
  endfunction

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [N*PW-1:0] p;
    logic [N-1:0] r;
    void'($urandom(32'd20240611));

    // R9: outputs during reset
    req = '1; prio = '1; thr = 5'h1F;
    repeat (3) @(negedge clk);
    check4("R9 reset", 1'b0, 6'h3F, 4'hF, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    req = '0; prio = '0; thr = '0;
    @(negedge clk);

    // R8: not visible before the edge, visible after it
    @(negedge clk);
    req = 64'd1 << 10; prio = set_nib('0, 10, 4'd7); thr = 5'd3;
    #1;
    check4("R8 before edge", 1'b0, 6'h3F, 4'hF, 1'b0);
    @(negedge clk);
    check4("R8 after edge", 1'b1, 6'd10, 4'd7, 1'b1);

    // R1: nibble placement
    p = '0;
    for (int s = 0; s < 8; s++) p = set_nib(p, s, 4'd1);
    p = set_nib(p, 5, 4'd9);
    apply("R1 word0 nibble5", 64'hFF, p, 5'd0);
    check4("R1 src5 bits23:20", 1'b1, 6'd5, 4'd9, 1'b1);
    p = set_nib(p, 40, 4'd12);
    apply("R1 word5 nibble0", 64'hFF | (64'd1 << 40), p, 5'd0);
    check4("R1 src40 bits163:160", 1'b1, 6'd40, 4'd12, 1'b1);

    // R2: highest priority wins regardless of index
    p = set_nib(set_nib(set_nib('0, 2, 4'd14), 50, 4'd3), 63, 4'd8);
    apply("R2 max prio", (64'd1 << 2) | (64'd1 << 50) | (64'd1 << 63), p, 5'd0);
    check4("R2 src2 prio14", 1'b1, 6'd2, 4'd14, 1'b1);

    // R3: tie goes to the highest index
    p = set_nib(set_nib(set_nib(set_nib('0, 3, 4'd6), 17, 4'd6), 60, 4'd6), 61, 4'd2);
    apply("R3 tie", (64'd1 << 3) | (64'd1 << 17) | (64'd1 << 60) | (64'd1 << 61), p, 5'd0);
    check4("R3 src60", 1'b1, 6'd60, 4'd6, 1'b1);
    apply("R3 all zero prio", '1, '0, 5'd0);
    check4("R3 src63 of all", 1'b1, 6'd63, 4'd0, 1'b0);

    // R4: lone priority-zero request
    apply("R4 lone zero", 64'd1 << 33, '0, 5'd0);
    check4("R4 src33 prio0", 1'b1, 6'd33, 4'd0, 1'b0);

    // R5: empty
    apply("R5 empty", '0, '1, 5'd0);
    check4("R5 empty thr0", 1'b0, 6'h3F, 4'hF, 1'b0);
    apply("R5 empty sat", '0, '1, 5'h1F);
    check4("R5 empty thr31", 1'b0, 6'h3F, 4'hF, 1'b0);

    // R6: strict threshold
    p = set_nib('0, 20, 4'd7);
    apply("R6 equal", 64'd1 << 20, p, 5'd7);
    check4("R6 prio7 thr7", 1'b1, 6'd20, 4'd7, 1'b0);
    apply("R6 below", 64'd1 << 20, p, 5'd6);
    check4("R6 prio7 thr6", 1'b1, 6'd20, 4'd7, 1'b1);
    p = set_nib('0, 20, 4'd15);
    apply("R6 thr15", 64'd1 << 20, p, 5'd15);
    check4("R6 prio15 thr15", 1'b1, 6'd20, 4'd15, 1'b0);
    apply("R6 thr16", 64'd1 << 20, p, 5'd16);
    check4("R6 prio15 thr16", 1'b1, 6'd20, 4'd15, 1'b0);

    // R7: saturated threshold
    apply("R7 sat zero prio", 64'd1 << 1, '0, 5'h1F);
    check4("R7 prio0 thr31", 1'b1, 6'd1, 4'd0, 1'b1);
    apply("R7 sat 30", 64'd1 << 1, '1, 5'h1E);
    check4("R7 prio15 thr30", 1'b1, 6'd1, 4'hF, 1'b0);

    // R10: priorities of idle sources ignored
    p = '1;
    p = set_nib(p, 5, 4'd3);
    apply("R10 high idle", 64'd1 << 5, p, 5'd2);
    check4("R10 src5 only", 1'b1, 6'd5, 4'd3, 1'b1);
    for (int k = 0; k < 20; k++) begin
      p = set_nib(rand_prio(1'b0), 5, 4'd3);
      apply("R10 random idle", 64'd1 << 5, p, 5'd2);
      check4("R10 unchanged", 1'b1, 6'd5, 4'd3, 1'b1);
    end

    // Random mix against the reference scan (R2 R3 R6 R7)
    for (int k = 0; k < 3000; k++) begin
      int mode = int'($urandom_range(0, 4));
      logic [TW-1:0] t;
      r = {$urandom, $urandom};
      case (mode)
        0: r = r & {$urandom, $urandom} & {$urandom, $urandom};
        1: r = 64'd1 << $urandom_range(0, 63);
        2: r = (k % 7 == 0) ? '0 : r;
        default: ;
      endcase
      t = ($urandom_range(0, 5) == 0) ? 5'h1F : TW'($urandom_range(0, 31));
      apply("R2/R3 random", r, rand_prio($urandom_range(0, 1) == 1), t);
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule